// File: doc/BRIEF.md
# I/O Page Register Slave with Interlocked Handshake

This block is the slave end of an asynchronous, multi-drop bus. It holds a small bank of device registers at a fixed base inside the reserved I/O region, which is the top 8 KB of an 18-bit byte address space. A bus master starts a transfer by placing an address and a two-bit cycle code on the bus and raising its sync strobe. The slave answers with its own sync strobe once read data is on the bus or write data has been stored. It keeps that strobe high until the master drops its strobe. There is no fixed timing: the slave may take as long as it needs.

Every bus input, including the bus initialise line, first passes through a synchronizer to the local clock. The block handles plain reads, word writes and byte writes. It also handles the read-with-pause that opens a read-modify-write. That cycle sets a lock flag, which stays up until the matching write to the same register arrives or the bus is initialised. One register in the bank carries live device status and cannot be written.

Top module: `iopage_slave`

## Requirements
- R1: With a matching address held, `bus_ssyn` rises on the third rising clock edge after `bus_msyn` goes high. It falls on the third rising edge after `bus_msyn` goes low.
- R2: The block responds only when address bits 17..13 are all ones and bits 17..3 equal those of `BASE_ADDR`. On any other address there is no `bus_ssyn`, no read data and no register change.
- R3: Cycle code 00 is a read. `bus_rdata_en` is high exactly while `bus_ssyn` is high for a read, and `bus_rdata` then holds the addressed register. Otherwise `bus_rdata` is zero.
- R4: Cycle code 10 is a word write. It replaces all 16 bits of the addressed register with `bus_wdata`.
- R5: Cycle code 11 is a byte write. With address bit 0 = 0 it loads bits 7..0 from `bus_wdata[7:0]`. With bit 0 = 1 it loads bits 15..8 from `bus_wdata[15:8]`. The other byte is kept.
- R6: Cycle code 01 is a read-with-pause. It returns data like a read and raises `rmw_lock`.
- R7: While `rmw_lock` is high, a word or byte write to the register index that set it clears the flag. A write to any other index leaves the flag set.
- R8: Address bits 2..1 select the register. Indices 0 to 2 are read/write. Index 3 returns `dev_status`, sampled when the access is taken. A write to index 3 is acknowledged and changes nothing.
- R9: A high `bus_init`, seen after synchronization, clears all writable registers and `rmw_lock`, and drops `bus_ssyn`.
- R10: While `bus_ssyn` is high, changes to the address, cycle code or write data cause no further access. Only the fall of `bus_msyn` ends the cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Local clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_init | input | 1 | Bus initialise, active high, asynchronous |
| bus_msyn | input | 1 | Master sync strobe, asynchronous |
| bus_ctl | input | 2 | Cycle code: 00 read, 01 read-pause, 10 word write, 11 byte write |
| bus_addr | input | 18 | Byte address |
| bus_wdata | input | 16 | Write data from the master |
| dev_status | input | 16 | Live status value returned at register index 3 |
| bus_ssyn | output | 1 | Slave sync acknowledge |
| bus_rdata | output | 16 | Read data, zero when not driving |
| bus_rdata_en | output | 1 | Read data valid |
| rmw_lock | output | 1 | Read-modify-write in progress |

## Verification
The hardest states to reach from the ports are the lock cases. The bench must open a read-pause, then send an intervening write to a different register without losing the lock, and later close it with a byte write to the locked index. It must also cut a locked state with a one-cycle initialise pulse that has to survive the synchronizer. A further case changes the address and cycle code to a write while the acknowledge is still held, which shows that no second access slips in. A behavioural model in the bench tracks the synchronizer delay with a two-deep input history. It checks the acknowledge, the read data and the lock every clock through all of these sequences.

// File: rtl/iop_pkg.sv
package iop_pkg;
    localparam int ADDR_W    = 18;
    localparam int DATA_W    = 16;
    localparam int PAGE_W    = 13;
    localparam int IDX_W     = 2;
    localparam int NREG      = 1 << IDX_W;
    localparam int IDX_LSB   = 1;
    localparam int MATCH_LSB = IDX_LSB + IDX_W;
    localparam int HALF_W    = DATA_W / 2;

    typedef enum logic [1:0] {
        CYC_READ       = 2'b00,
        CYC_READ_HOLD  = 2'b01,
        CYC_WRITE      = 2'b10,
        CYC_WRITE_BYTE = 2'b11
    } cyc_e;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_ACK  = 2'd1,
        ST_MISS = 2'd2
    } state_e;

    typedef struct packed {
        logic              init;
        logic              msyn;
        cyc_e              cyc;
        logic [ADDR_W-1:0] addr;
        logic [DATA_W-1:0] wdata;
    } bus_in_t;

    localparam int BUS_IN_W = $bits(bus_in_t);

    function automatic logic cyc_writes(cyc_e c);
        return c[1];
    endfunction

    function automatic logic [DATA_W-1:0] lane_merge(
        logic [DATA_W-1:0] prev,
        logic [DATA_W-1:0] incoming,
        logic              byte_mode,
        logic              upper
    );
        logic [DATA_W-1:0] r;
        r = incoming;
        if (byte_mode) begin
            if (upper) r = {incoming[DATA_W-1:HALF_W], prev[HALF_W-1:0]};
            else       r = {prev[DATA_W-1:HALF_W], incoming[HALF_W-1:0]};
        end
        return r;
    endfunction
endpackage

// File: rtl/iop_sync.sv
module iop_sync #(
    parameter int W      = 1,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [STAGES-1:0][W-1:0] chain;

    always_ff @(posedge clk) begin
        if (rst) begin
            chain <= '0;
        end else begin
            chain[0] <= d;
            for (int k = 1; k < STAGES; k++) begin
                chain[k] <= chain[k-1];
            end
        end
    end

    assign q = chain[STAGES-1];
endmodule

// File: rtl/iop_decode.sv
module iop_decode
    import iop_pkg::*;
#(
    parameter logic [ADDR_W-1:0] BASE_ADDR = 18'h3FF40
) (
    input  logic [ADDR_W-1:0] addr,
    output logic              hit,
    output logic [IDX_W-1:0]  idx,
    output logic              upper
);
    logic in_page;
    logic base_eq;

    assign in_page = &addr[ADDR_W-1:PAGE_W];
    assign base_eq = (addr[ADDR_W-1:MATCH_LSB] == BASE_ADDR[ADDR_W-1:MATCH_LSB]);
    assign hit     = in_page && base_eq;
    assign idx     = addr[MATCH_LSB-1:IDX_LSB];
    assign upper   = addr[0];
endmodule

// File: rtl/iop_regbank.sv
module iop_regbank
    import iop_pkg::*;
#(
    parameter int RO_IDX = 3
) (
    input  logic              clk,
    input  logic              clr,
    input  logic              wr_en,
    input  logic              wr_byte,
    input  logic              wr_upper,
    input  logic [IDX_W-1:0]  wr_idx,
    input  logic [DATA_W-1:0] wr_data,
    input  logic [IDX_W-1:0]  rd_idx,
    input  logic [DATA_W-1:0] status_in,
    output logic [DATA_W-1:0] rd_data
);
    logic [NREG-1:0][DATA_W-1:0] store;

    always_ff @(posedge clk) begin
        if (clr) begin
            store <= '0;
        end else begin
            for (int i = 0; i < NREG; i++) begin
                if (wr_en && (wr_idx == IDX_W'(i)) && (i != RO_IDX)) begin
                    store[i] <= lane_merge(store[i], wr_data, wr_byte, wr_upper);
                end
            end
        end
    end

    always_comb begin
        if (rd_idx == IDX_W'(RO_IDX)) rd_data = status_in;
        else                          rd_data = store[rd_idx];
    end

    AST_BANK_QUIET: assert property (@(posedge clk) disable iff (clr)
        !wr_en |=> $stable(store));                          // R4
    AST_RO_IGNORED: assert property (@(posedge clk) disable iff (clr)
        (wr_en && wr_idx == IDX_W'(RO_IDX)) |=> $stable(store)); // R8
endmodule

// File: rtl/iopage_slave.sv
module iopage_slave
    import iop_pkg::*;
#(
    parameter logic [ADDR_W-1:0] BASE_ADDR   = 18'h3FF40,
    parameter int                SYNC_STAGES = 2,
    parameter int                RO_IDX      = 3
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              bus_init,
    input  logic              bus_msyn,
    input  logic [1:0]        bus_ctl,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    input  logic [DATA_W-1:0] dev_status,
    output logic              bus_ssyn,
    output logic [DATA_W-1:0] bus_rdata,
    output logic              bus_rdata_en,
    output logic              rmw_lock
);
    bus_in_t raw_in;
    bus_in_t sb;
    logic [BUS_IN_W-1:0] sb_bits;

    assign raw_in = '{init: bus_init, msyn: bus_msyn, cyc: cyc_e'(bus_ctl),
                      addr: bus_addr, wdata: bus_wdata};

    iop_sync #(.W(BUS_IN_W), .STAGES(SYNC_STAGES)) u_sync (
        .clk (clk),
        .rst (rst),
        .d   (raw_in),
        .q   (sb_bits)
    );
    assign sb = bus_in_t'(sb_bits);

    logic             hit;
    logic [IDX_W-1:0] idx;
    logic             upper;

    iop_decode #(.BASE_ADDR(BASE_ADDR)) u_dec (
        .addr  (sb.addr),
        .hit   (hit),
        .idx   (idx),
        .upper (upper)
    );

    state_e            state_q;
    logic              ssyn_q;
    logic              rd_q;
    logic [DATA_W-1:0] dout_q;
    logic              lock_q;
    logic [IDX_W-1:0]  lock_idx_q;
    logic              clr;
    logic              take;
    logic              wr_en;
    logic [DATA_W-1:0] rd_data;

    assign clr   = rst || sb.init;
    assign take  = (state_q == ST_IDLE) && sb.msyn && hit;
    assign wr_en = take && cyc_writes(sb.cyc);

    iop_regbank #(.RO_IDX(RO_IDX)) u_bank (
        .clk       (clk),
        .clr       (clr),
        .wr_en     (wr_en),
        .wr_byte   (sb.cyc == CYC_WRITE_BYTE),
        .wr_upper  (upper),
        .wr_idx    (idx),
        .wr_data   (sb.wdata),
        .rd_idx    (idx),
        .status_in (dev_status),
        .rd_data   (rd_data)
    );

    always_ff @(posedge clk) begin
        if (clr) begin
            state_q    <= ST_IDLE;
            ssyn_q     <= 1'b0;
            rd_q       <= 1'b0;
            dout_q     <= '0;
            lock_q     <= 1'b0;
            lock_idx_q <= '0;
        end else begin
            case (state_q)
                ST_IDLE: begin
                    if (sb.msyn) begin
                        if (hit) begin
                            state_q <= ST_ACK;
                            ssyn_q  <= 1'b1;
                            if (!cyc_writes(sb.cyc)) begin
                                rd_q   <= 1'b1;
                                dout_q <= rd_data;
                                if (sb.cyc == CYC_READ_HOLD) begin
                                    lock_q     <= 1'b1;
                                    lock_idx_q <= idx;
                                end
                            end else if (lock_q && (idx == lock_idx_q)) begin
                                lock_q <= 1'b0;
                            end
                        end else begin
                            state_q <= ST_MISS;
                        end
                    end
                end
                ST_ACK: begin
                    if (!sb.msyn) begin
                        state_q <= ST_IDLE;
                        ssyn_q  <= 1'b0;
                        rd_q    <= 1'b0;
                        dout_q  <= '0;
                    end
                end
                ST_MISS: begin
                    if (!sb.msyn) state_q <= ST_IDLE;
                end
                default: state_q <= ST_IDLE;
            endcase
        end
    end

    assign bus_ssyn     = ssyn_q;
    assign bus_rdata    = dout_q;
    assign bus_rdata_en = rd_q;
    assign rmw_lock     = lock_q;

    AST_ACK_AFTER_MSYN: assert property (@(posedge clk) disable iff (rst)
        $rose(ssyn_q) |-> $past(sb.msyn));                   // R1
    AST_ACK_ONLY_ON_HIT: assert property (@(posedge clk) disable iff (rst)
        $rose(ssyn_q) |-> $past(hit));                       // R2
    AST_ACK_HELD: assert property (@(posedge clk) disable iff (rst)
        (ssyn_q && sb.msyn && !sb.init) |=> ssyn_q);         // R10
    AST_LOCK_FROM_PAUSE: assert property (@(posedge clk) disable iff (rst)
        $rose(lock_q) |-> $past(sb.cyc == CYC_READ_HOLD));   // R6
    AST_INIT_CLEARS: assert property (@(posedge clk) disable iff (rst)
        sb.init |=> (!lock_q && !ssyn_q));                   // R9
endmodule

// File: tb/test_iopage_slave.sv
module test_iopage_slave;
    import iop_pkg::*;

    localparam int CLK_PERIOD = 10;
    localparam logic [17:0] BASE = 18'h3FF40;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic init_i = 1'b0;
    logic msyn_i = 1'b0;
    logic [1:0] ctl_i = 2'b00;
    logic [17:0] addr_i = '0;
    logic [15:0] din_i = '0;
    logic [15:0] stat_i = 16'h5A0F;
    logic ssyn, rd_en, lock;
    logic [15:0] rdata;

    int n_chk = 0;
    int n_bad = 0;
    bit finished = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    iopage_slave #(.BASE_ADDR(BASE)) i_iopage_slave (
        .clk(clk), .rst(rst), .bus_init(init_i), .bus_msyn(msyn_i),
        .bus_ctl(ctl_i), .bus_addr(addr_i), .bus_wdata(din_i),
        .dev_status(stat_i), .bus_ssyn(ssyn), .bus_rdata(rdata),
        .bus_rdata_en(rd_en), .rmw_lock(lock)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // Behavioural reference: input history two edges deep, then cycle rules.
    logic [37:0] h1, h2, cur;
    logic m_ssyn, m_rd, m_lock, m_miss;
    logic [15:0] m_dout;
    logic [1:0] m_lidx;
    logic [15:0] m_reg [4];

    always @(posedge clk) begin
        if (rst) begin
            h1 = '0; h2 = '0;
            m_ssyn = 0; m_rd = 0; m_lock = 0; m_miss = 0; m_dout = 0; m_lidx = 0;
            for (int r = 0; r < 4; r++) m_reg[r] = 0;
        end else begin
            cur = h2;
            if (cur[37]) begin
                m_ssyn = 0; m_rd = 0; m_lock = 0; m_miss = 0; m_dout = 0; m_lidx = 0;
                for (int r = 0; r < 4; r++) m_reg[r] = 0;
            end else if (m_ssyn) begin
                if (!cur[36]) begin m_ssyn = 0; m_rd = 0; m_dout = 0; end
            end else if (m_miss) begin
                if (!cur[36]) m_miss = 0;
            end else if (cur[36]) begin
                logic [17:0] a;
                logic [15:0] w;
                int ri;
                a = cur[33:16];
                w = cur[15:0];
                if (a[17:13] == 5'h1F && a[17:3] == BASE[17:3]) begin
                    ri = int'(a[2:1]);
                    m_ssyn = 1;
                    if (cur[35] == 1'b0) begin
                        m_rd = 1;
                        m_dout = (ri == 3) ? stat_i : m_reg[ri];
                        if (cur[34]) begin m_lock = 1; m_lidx = a[2:1]; end
                    end else begin
                        if (ri != 3) begin
                            if (!cur[34]) m_reg[ri] = w;
                            else if (a[0]) m_reg[ri][15:8] = w[15:8];
                            else m_reg[ri][7:0] = w[7:0];
                        end
                        if (m_lock && m_lidx == a[2:1]) m_lock = 0;
                    end
                end else begin
                    m_miss = 1;
                end
            end
            h2 = h1;
            h1 = {init_i, msyn_i, ctl_i, addr_i, din_i};
        end
    end

    always @(negedge clk) begin
        if (!rst && !finished) begin
            chk("R1 ssyn vs model", {31'd0, ssyn}, {31'd0, m_ssyn});
            chk("R3 rdata_en vs model", {31'd0, rd_en}, {31'd0, m_rd});
            chk("R3 rdata vs model", {16'd0, rdata}, {16'd0, m_dout});
            chk("R7 lock vs model", {31'd0, lock}, {31'd0, m_lock});
        end
    end

    int lat;

    task automatic bus_cycle(input logic [17:0] a, input logic [1:0] c, input logic [15:0] d,
                             input bit wiggle, output logic [15:0] rv, output bit acked);
        acked = 0; rv = '0;
        @(negedge clk); addr_i = a; ctl_i = c; din_i = d;
        @(negedge clk); msyn_i = 1'b1;
        lat = 0;
        for (int k = 0; k < 8; k++) begin
            @(negedge clk);
            lat++;
            if (ssyn) begin acked = 1; rv = rdata; break; end
        end
        if (wiggle && acked) begin
            addr_i = BASE + 18'd2; ctl_i = 2'b10; din_i = 16'hDEAD;
            repeat (4) @(negedge clk);
        end
        msyn_i = 1'b0;
        for (int k = 0; k < 8; k++) begin
            @(negedge clk);
            if (!ssyn) break;
        end
        repeat (2) @(negedge clk);
    endtask

    initial begin
        logic [15:0] v;
        bit ok;
        repeat (3) @(negedge clk);
        chk("R1 reset ssyn", {31'd0, ssyn}, 32'd0);
        chk("R3 reset rdata_en", {31'd0, rd_en}, 32'd0);
        chk("R6 reset lock", {31'd0, lock}, 32'd0);
        rst = 1'b0;
        repeat (2) @(negedge clk);

        bus_cycle(BASE, 2'b00, 16'h0, 0, v, ok);
        chk("R3 read after reset", {16'd0, v}, 32'h0);
        chk("R1 ack latency", lat, 3);

        bus_cycle(BASE, 2'b10, 16'hA5C3, 0, v, ok);
        chk("R4 word write acked", {31'd0, ok}, 32'd1);
        bus_cycle(BASE, 2'b00, 16'h0, 0, v, ok);
        chk("R4 word write readback", {16'd0, v}, 32'hA5C3);

        bus_cycle(BASE + 18'd2, 2'b10, 16'h1111, 0, v, ok);
        bus_cycle(BASE + 18'd2, 2'b11, 16'hEE77, 0, v, ok);
        bus_cycle(BASE + 18'd2, 2'b00, 16'h0, 0, v, ok);
        chk("R5 low byte write", {16'd0, v}, 32'h1177);
        bus_cycle(BASE + 18'd3, 2'b11, 16'h9900, 0, v, ok);
        bus_cycle(BASE + 18'd2, 2'b00, 16'h0, 0, v, ok);
        chk("R5 high byte write", {16'd0, v}, 32'h9977);

        bus_cycle(BASE + 18'd6, 2'b10, 16'hFFFF, 0, v, ok);
        chk("R8 status write acked", {31'd0, ok}, 32'd1);
        bus_cycle(BASE + 18'd6, 2'b00, 16'h0, 0, v, ok);
        chk("R8 status unchanged", {16'd0, v}, 32'h5A0F);
        stat_i = 16'h0C30;
        bus_cycle(BASE + 18'd6, 2'b00, 16'h0, 0, v, ok);
        chk("R8 status live", {16'd0, v}, 32'h0C30);

        bus_cycle(BASE + 18'd8, 2'b10, 16'h4444, 0, v, ok);
        chk("R2 neighbour miss", {31'd0, ok}, 32'd0);
        bus_cycle({5'h00, BASE[12:0]}, 2'b10, 16'h5555, 0, v, ok);
        chk("R2 outside page miss", {31'd0, ok}, 32'd0);
        bus_cycle(BASE, 2'b00, 16'h0, 0, v, ok);
        chk("R2 reg untouched by miss", {16'd0, v}, 32'hA5C3);

        bus_cycle(BASE, 2'b00, 16'h0, 1, v, ok);
        bus_cycle(BASE + 18'd2, 2'b00, 16'h0, 0, v, ok);
        chk("R10 no second access", {16'd0, v}, 32'h9977);

        bus_cycle(BASE + 18'd4, 2'b10, 16'h0F0F, 0, v, ok);
        bus_cycle(BASE + 18'd4, 2'b01, 16'h0, 0, v, ok);
        chk("R6 pause read data", {16'd0, v}, 32'h0F0F);
        chk("R6 lock set", {31'd0, lock}, 32'd1);
        bus_cycle(BASE, 2'b10, 16'h2222, 0, v, ok);
        chk("R7 other index keeps lock", {31'd0, lock}, 32'd1);
        bus_cycle(BASE + 18'd5, 2'b11, 16'hAB00, 0, v, ok);
        chk("R7 matching write clears lock", {31'd0, lock}, 32'd0);
        bus_cycle(BASE + 18'd4, 2'b00, 16'h0, 0, v, ok);
        chk("R7 rmw result", {16'd0, v}, 32'hAB0F);

        bus_cycle(BASE + 18'd4, 2'b01, 16'h0, 0, v, ok);
        @(negedge clk); init_i = 1'b1;
        @(negedge clk); init_i = 1'b0;
        repeat (3) @(negedge clk);
        chk("R9 init clears lock", {31'd0, lock}, 32'd0);
        bus_cycle(BASE, 2'b00, 16'h0, 0, v, ok);
        chk("R9 init clears reg", {16'd0, v}, 32'h0);

        finished = 1;
        $display("test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            finished = 1;
            n_chk++; n_bad++;
            $display("FAIL watchdog actual=running expected=done");
            $display("test done: total=%0d bad=%0d", n_chk, n_bad);
            $finish;
        end
    end
endmodule